// File: doc/BRIEF.md
# Two-Stage Deadline Watchdog

The block watches a free-running 64-bit system count supplied from outside and compares it every cycle against a stored 64-bit deadline. It has no prescaler and no counter of its own. When the watchdog is enabled and the count reaches the deadline, the block raises a warning. It sets the stage-0 flag, asserts an interrupt, and re-arms itself by loading a new deadline: the current count plus a 32-bit offset. If software does not service the warning before the re-armed deadline passes, the stage-1 flag is set and a reset request is asserted.

Software reaches the block through two simple memory-mapped frames. Each frame has a request, write enable, address and read data, and read data is combinational. The refresh frame carries only the keep-alive register. A write there, with any data, services the watchdog. The control frame holds the enable and status word, the offset and the two halves of the deadline. Software can write the deadline directly, so the first watch period may be longer than the offset can express. Both frames return a fixed interface identifier.

Top module: `dual_stage_wdt`

## Requirements
- R1: After rst_ni is released, the enable bit, both stage flags, the offset and the deadline all read zero, and irq_o and rst_req_o are low.
- R2: Any write to refresh-frame address 0x000 clears the stage-0 flag. On the next edge it loads the deadline with the current count plus the offset.
- R3: A control-frame write to 0x000 takes the enable from data bit 0. A write to 0x008 stores the 32-bit offset. Both also act as a refresh as in R2; for an offset write, the new offset is the one added.
- R4: Control-frame writes to 0x010 and 0x014 replace the low and high 32 bits of the deadline. They leave both stage flags unchanged and start no reload.
- R5: When enabled, with the stage-0 flag clear and the count greater than or equal to the deadline, the next edge sets the stage-0 flag (irq_o high). The same edge loads the deadline with count plus offset.
- R6: When enabled, with the stage-0 flag set and the count greater than or equal to the deadline, the next edge sets the stage-1 flag and asserts rst_req_o.
- R7: The stage-1 flag and rst_req_o stay set until rst_ni. Refresh writes do not clear them.
- R8: With the enable bit clear, no expiry occurs and the stored deadline keeps its value.
- R9: The control-frame word at 0x000 reads enable in bit 0, stage-0 in bit 1 and stage-1 in bit 2. Address 0xFCC in either frame reads 0x0001A5D3. Every other address, refresh-frame 0x000 included, reads zero, and so does any cycle with no read request.
- R10: In a cycle where a refresh coincides with an expiry or with a deadline-half write, the refresh takes effect and the other is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_cnt_i | input | 64 | External system count |
| rf_req_i | input | 1 | Refresh-frame access request |
| rf_we_i | input | 1 | Refresh-frame write enable |
| rf_addr_i | input | 12 | Refresh-frame byte address |
| rf_rdata_o | output | 32 | Refresh-frame read data |
| cf_req_i | input | 1 | Control-frame access request |
| cf_we_i | input | 1 | Control-frame write enable |
| cf_addr_i | input | 12 | Control-frame byte address |
| cf_wdata_i | input | 32 | Control-frame write data |
| cf_rdata_o | output | 32 | Control-frame read data |
| irq_o | output | 1 | Stage-0 warning interrupt (level) |
| rst_req_o | output | 1 | Stage-1 reset request (sticky) |

## Verification
A corrupted deadline does not show as a single wrong bit. It shows as an interrupt that arrives a cycle early or late, or as a stage-1 reset that never follows. The bench therefore compares irq_o and rst_req_o against its model on every cycle. It also reads the deadline halves, offset and status back through the control frame each cycle. A wrong reload sum, a lost flag or a wrong priority between refresh and expiry then appears within one clock, before the timing consequence shows.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_REFRESH  = 12'h000;
  localparam logic [ADDR_W-1:0] A_CTRL     = 12'h000;
  localparam logic [ADDR_W-1:0] A_OFFSET   = 12'h008;
  localparam logic [ADDR_W-1:0] A_CMP_LO   = 12'h010;
  localparam logic [ADDR_W-1:0] A_IFACE_ID = 12'hFCC;

  typedef struct packed {
    logic refresh;
    logic ctrl_wr;
    logic off_wr;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
  import wdt_pkg::*;
#(
  parameter int          CNT_W    = 64,
  parameter int          BUS_W    = 32,
  parameter int          OFF_W    = 32,
  parameter logic [31:0] IFACE_ID = 32'h0001_A5D3,
  parameter int          NW       = CNT_W / BUS_W
) (
  input  logic              rf_req_i,
  input  logic              rf_we_i,
  input  logic [ADDR_W-1:0] rf_addr_i,
  output logic [BUS_W-1:0]  rf_rdata_o,
  input  logic              cf_req_i,
  input  logic              cf_we_i,
  input  logic [ADDR_W-1:0] cf_addr_i,
  output logic [BUS_W-1:0]  cf_rdata_o,
  input  logic              en_i,
  input  logic              st0_i,
  input  logic              st1_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [CNT_W-1:0]  cmp_i,
  output wdt_strobe_t       stb_o,
  output logic [NW-1:0]     cmp_word_wr_o
);
  localparam int WORD_BYTES = BUS_W / 8;

  function automatic logic [ADDR_W-1:0] word_addr(input int idx);
    return ADDR_W'(int'(A_CMP_LO) + idx * WORD_BYTES);
  endfunction

  logic cf_wr, cf_rd, rf_kick;
  logic [BUS_W-1:0] cf_mux;

  assign cf_wr   = cf_req_i & cf_we_i;
  assign cf_rd   = cf_req_i & ~cf_we_i;
  assign rf_kick = rf_req_i & rf_we_i & (rf_addr_i == A_REFRESH);

  assign stb_o.ctrl_wr = cf_wr & (cf_addr_i == A_CTRL);
  assign stb_o.off_wr  = cf_wr & (cf_addr_i == A_OFFSET);
  assign stb_o.refresh = rf_kick | stb_o.ctrl_wr | stb_o.off_wr;

  for (genvar gi = 0; gi < NW; gi++) begin : g_cmp_wr
    assign cmp_word_wr_o[gi] = cf_wr & (cf_addr_i == word_addr(gi));
  end

  always_comb begin
    cf_mux = '0;
    if (cf_addr_i == A_CTRL)     cf_mux = BUS_W'({st1_i, st0_i, en_i});
    if (cf_addr_i == A_OFFSET)   cf_mux = BUS_W'(offset_i);
    if (cf_addr_i == A_IFACE_ID) cf_mux = BUS_W'(IFACE_ID);
    for (int i = 0; i < NW; i++) begin
      if (cf_addr_i == word_addr(i)) cf_mux = cmp_i[i*BUS_W +: BUS_W];
    end
  end

  assign cf_rdata_o = cf_rd ? cf_mux : '0;
  assign rf_rdata_o = (rf_req_i & ~rf_we_i & (rf_addr_i == A_IFACE_ID)) ? BUS_W'(IFACE_ID) : '0;
endmodule

// File: rtl/wdt_deadline.sv
module wdt_deadline #(
  parameter int CNT_W = 64,
  parameter int BUS_W = 32,
  parameter int NW    = CNT_W / BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] sys_cnt_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_off_i,
  input  logic [NW-1:0]    word_wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cmp_q;

  // reload has priority over a direct half write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else if (reload_i) begin
      cmp_q <= sys_cnt_i + reload_off_i;
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (word_wr_i[i]) cmp_q[i*BUS_W +: BUS_W] <= wdata_i;
      end
    end
  end

  assign cmp_o = cmp_q;
  assign hit_o = (sys_cnt_i >= cmp_q);
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hit_i,
  input  logic refresh_i,
  output logic st0_o,
  output logic st1_o,
  output logic fire0_o
);
  logic st0_q, st1_q, expire, fire1;

  assign expire  = en_i & hit_i & ~refresh_i;
  assign fire0_o = expire & ~st0_q;
  assign fire1   = expire & st0_q & ~st1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st0_q <= 1'b0;
      st1_q <= 1'b0;
    end else begin
      if (refresh_i)    st0_q <= 1'b0;
      else if (fire0_o) st0_q <= 1'b1;
      if (fire1)        st1_q <= 1'b1;  // sticky until reset
    end
  end

  assign st0_o = st0_q;
  assign st1_o = st1_q;
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
  import wdt_pkg::*;
#(
  parameter int          CNT_W    = 64,
  parameter int          BUS_W    = 32,
  parameter int          OFF_W    = 32,
  parameter logic [31:0] IFACE_ID = 32'h0001_A5D3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  sys_cnt_i,
  input  logic              rf_req_i,
  input  logic              rf_we_i,
  input  logic [ADDR_W-1:0] rf_addr_i,
  output logic [BUS_W-1:0]  rf_rdata_o,
  input  logic              cf_req_i,
  input  logic              cf_we_i,
  input  logic [ADDR_W-1:0] cf_addr_i,
  input  logic [BUS_W-1:0]  cf_wdata_i,
  output logic [BUS_W-1:0]  cf_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int NW = CNT_W / BUS_W;

  wdt_strobe_t      stb;
  logic [NW-1:0]    cmp_word_wr;
  logic             refresh;
  logic             en_q;
  logic [OFF_W-1:0] offset_q, offset_nxt;
  logic [CNT_W-1:0] cmp_q;
  logic             hit, st0, st1, fire0;

  assign refresh    = stb.refresh;
  assign offset_nxt = stb.off_wr ? cf_wdata_i[OFF_W-1:0] : offset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      offset_q <= '0;
    end else begin
      if (stb.ctrl_wr) en_q <= cf_wdata_i[0];
      offset_q <= offset_nxt;
    end
  end

  wdt_bus_decode #(
    .CNT_W(CNT_W), .BUS_W(BUS_W), .OFF_W(OFF_W), .IFACE_ID(IFACE_ID), .NW(NW)
  ) i_decode (
    .rf_req_i, .rf_we_i, .rf_addr_i, .rf_rdata_o,
    .cf_req_i, .cf_we_i, .cf_addr_i, .cf_rdata_o,
    .en_i(en_q), .st0_i(st0), .st1_i(st1), .offset_i(offset_q), .cmp_i(cmp_q),
    .stb_o(stb), .cmp_word_wr_o(cmp_word_wr)
  );

  wdt_deadline #(.CNT_W(CNT_W), .BUS_W(BUS_W), .NW(NW)) i_deadline (
    .clk_i, .rst_ni, .sys_cnt_i,
    .reload_i(refresh | fire0),
    .reload_off_i(CNT_W'(offset_nxt)),
    .word_wr_i(cmp_word_wr),
    .wdata_i(cf_wdata_i),
    .cmp_o(cmp_q),
    .hit_o(hit)
  );

  wdt_stage i_stage (
    .clk_i, .rst_ni,
    .en_i(en_q), .hit_i(hit), .refresh_i(refresh),
    .st0_o(st0), .st1_o(st1), .fire0_o(fire0)
  );

  assign irq_o     = st0;
  assign rst_req_o = st1;
endmodule

// File: rtl/dual_stage_wdt_checker.sv
module dual_stage_wdt_checker #(
  parameter int CNT_W = 64,
  parameter int OFF_W = 32,
  parameter int NW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] sys_cnt_i,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             en_q,
  input logic [OFF_W-1:0] offset_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic             refresh,
  input logic [NW-1:0]    cmp_word_wr
);
  a_r2_refresh_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |=> !irq_o);

  a_r4_cmp_write_keeps_stage0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cmp_word_wr) && !refresh && irq_o) |=> irq_o);

  a_r5_rearm_on_warning: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (cmp_q == $past(sys_cnt_i + CNT_W'(offset_q))));

  a_r6_reset_after_warning: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(irq_o));

  a_r7_reset_request_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  a_r8_no_warning_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_q));
endmodule

bind dual_stage_wdt dual_stage_wdt_checker #(.CNT_W(CNT_W), .OFF_W(OFF_W), .NW(NW)) i_chk (
  .clk_i, .rst_ni, .sys_cnt_i, .irq_o, .rst_req_o,
  .en_q, .offset_q, .cmp_q, .refresh, .cmp_word_wr
);

// File: tb/test_dual_stage_wdt.sv
`timescale 1ns/1ps
module test_dual_stage_wdt;
  localparam logic [31:0] ID = 32'h0001_A5D3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_cnt = 64'd100;
  logic        rf_req = 1'b0, rf_we = 1'b0;
  logic [11:0] rf_addr = '0;
  logic [31:0] rf_rdata;
  logic        cf_req = 1'b0, cf_we = 1'b0;
  logic [11:0] cf_addr = '0;
  logic [31:0] cf_wdata = '0;
  logic [31:0] cf_rdata;
  logic        irq, rst_req;

  int compared = 0, mismatched = 0;
  string tag = "R1";

  // reference model state
  logic        m_en, m_s0, m_s1;
  logic [31:0] m_off;
  logic [63:0] m_cmp;

  always #2 clk = ~clk;

  dual_stage_wdt i_dual_stage_wdt (
    .clk_i(clk), .rst_ni(rst_n), .sys_cnt_i(sys_cnt),
    .rf_req_i(rf_req), .rf_we_i(rf_we), .rf_addr_i(rf_addr), .rf_rdata_o(rf_rdata),
    .cf_req_i(cf_req), .cf_we_i(cf_we), .cf_addr_i(cf_addr), .cf_wdata_i(cf_wdata),
    .cf_rdata_o(cf_rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] read_cf();
    if (!(cf_req && !cf_we)) return '0;
    case (cf_addr)
      12'h000: return {29'b0, m_s1, m_s0, m_en};
      12'h008: return m_off;
      12'h010: return m_cmp[31:0];
      12'h014: return m_cmp[63:32];
      12'hFCC: return ID;
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] read_rf();
    return (rf_req && !rf_we && rf_addr == 12'hFCC) ? ID : '0;
  endfunction

  task automatic model_update();
    logic cw, ctrl, offw, refresh, hit;
    logic [31:0] noff;
    if (!rst_n) begin
      m_en = 0; m_s0 = 0; m_s1 = 0; m_off = '0; m_cmp = '0;
      return;
    end
    cw      = cf_req && cf_we;
    ctrl    = cw && cf_addr == 12'h000;
    offw    = cw && cf_addr == 12'h008;
    refresh = (rf_req && rf_we && rf_addr == 12'h000) || ctrl || offw;
    noff    = offw ? cf_wdata : m_off;
    hit     = m_en && (sys_cnt >= m_cmp);
    if (refresh) begin
      m_s0 = 0; m_off = noff; m_cmp = sys_cnt + {32'b0, noff};
      if (ctrl) m_en = cf_wdata[0];
    end else begin
      if (cw && cf_addr == 12'h010) m_cmp[31:0]  = cf_wdata;
      if (cw && cf_addr == 12'h014) m_cmp[63:32] = cf_wdata;
      if (hit && !m_s0) begin
        m_s0 = 1; m_cmp = sys_cnt + {32'b0, m_off};
      end else if (hit && !m_s1) begin
        m_s1 = 1;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("irq_o", {31'b0, irq}, {31'b0, m_s0});
    chk("rst_req_o", {31'b0, rst_req}, {31'b0, m_s1});
    chk("cf_rdata_o", cf_rdata, read_cf());
    chk("rf_rdata_o", rf_rdata, read_rf());
    sys_cnt = sys_cnt + 64'd1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cf_req = 1; cf_we = 0;
      case (i % 4)
        0: cf_addr = 12'h000;
        1: cf_addr = 12'h010;
        2: cf_addr = 12'h014;
        default: cf_addr = 12'h008;
      endcase
      rf_req = 1; rf_we = 0;
      rf_addr = (i % 2) ? 12'hFCC : 12'h000;
      step();
    end
  endtask

  task automatic cf_write(logic [11:0] a, logic [31:0] d);
    rf_req = 0; rf_we = 0;
    cf_req = 1; cf_we = 1; cf_addr = a; cf_wdata = d;
    step();
    cf_we = 0;
  endtask

  task automatic cf_read(logic [11:0] a);
    cf_req = 1; cf_we = 0; cf_addr = a;
    step();
  endtask

  task automatic rf_refresh();
    cf_req = 0; cf_we = 0;
    rf_req = 1; rf_we = 1; rf_addr = 12'h000;
    step();
    rf_we = 0;
  endtask

  task automatic refresh_and_cmp(logic [11:0] a, logic [31:0] d);
    rf_req = 1; rf_we = 1; rf_addr = 12'h000;
    cf_req = 1; cf_we = 1; cf_addr = a; cf_wdata = d;
    step();
    rf_we = 0; cf_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tag = "R1"; do_reset(); idle(8);
    tag = "R9"; cf_read(12'hFCC); cf_read(12'h020); cf_read(12'h004);
    rf_req = 1; rf_we = 0; rf_addr = 12'h008; step();
    rf_addr = 12'hFCC; step();
    cf_req = 0; rf_req = 0; step();
    tag = "R3"; cf_write(12'h008, 32'd20); idle(4);
    cf_write(12'h000, 32'd1); idle(2);
    tag = "R5"; idle(25);
    tag = "R2"; rf_refresh(); idle(5);
    tag = "R6"; idle(50);
    tag = "R7"; rf_refresh(); idle(3); cf_write(12'h000, 32'd1); idle(30);
    tag = "R1"; do_reset(); idle(4);
    tag = "R4"; cf_write(12'h008, 32'h1000_0000); cf_write(12'h000, 32'd1);
    cf_write(12'h010, 32'h0000_0500); cf_write(12'h014, 32'h0000_0001); idle(6);
    sys_cnt = 64'h1_0000_04FC; idle(8);
    cf_write(12'h010, 32'h0000_0000); idle(4);
    tag = "R1"; do_reset(); idle(2);
    tag = "R8"; cf_write(12'h008, 32'd10); cf_write(12'h000, 32'd1); idle(3);
    cf_write(12'h000, 32'd0); idle(30);
    sys_cnt = 64'hFFFF_FFFF_0000_0000; idle(6);
    tag = "R10"; cf_write(12'h008, 32'd0); cf_write(12'h000, 32'd1);
    for (int i = 0; i < 5; i++) rf_refresh();
    idle(3);
    refresh_and_cmp(12'h014, 32'h0000_0000); idle(2);
    refresh_and_cmp(12'h010, 32'hFFFF_FFFF); idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule